// File: doc/BRIEF.md
# Reservation Station Bank with Operand Capture

This block holds instructions that wait for one functional unit. Each entry keeps an operation code and two operand slots. Each slot is a pair of a value and a tag. A tag of zero means the slot already holds a real value. A nonzero tag names the producer whose result has not arrived yet.

At issue, the lowest free entry is filled from the issue port. The bank watches a common result bus every cycle. When a broadcast tag matches a slot's tag, that slot takes the broadcast value and its tag becomes zero. The two slots capture independently, so one operand may arrive many cycles before the other. An entry whose two slots hold values is ready. One ready entry per cycle is sent to the functional unit, chosen by lowest index, but only while the unit is not busy.

The unit is modelled as busy for `FU_LAT` cycles after each send. An entry is freed only when the bus broadcasts that entry's own tag, which marks its result as written. The tag has the unit-type code in the upper bits and the entry index in the lower bits.

Top module: `rs_bank`

## Requirements
- R1: After reset, `iss_stall` and `disp_valid` are both 0.
- R2: An accepted issue fills the lowest-indexed free entry. That entry's tag is `{UNIT_CODE, index}`, with the unit code in the upper `UNIT_W` bits and the entry index in the lower bits. This tag is the value presented on `disp_tag` when the entry is sent.
- R3: While every entry is occupied, `iss_stall` is 1. An issue request in such a cycle allocates nothing and is never sent later.
- R4: An operand given with tag 0 is used as a value. An operand given with a nonzero tag waits until `bus_valid` carries that same tag, then stores `bus_value`.
- R5: The two operand slots of one entry capture their values independently, in different cycles and from different producer tags.
- R6: If the bus carries a slot's producer tag in the same cycle that the instruction issues, the slot captures the value in that cycle.
- R7: An entry is never sent while either of its slots still waits on a tag.
- R8: When several entries are ready, the lowest-indexed one is sent first.
- R9: After a send, no further send occurs until `FU_LAT` cycles have passed.
- R10: A sent entry is not sent again. It stays occupied until the bus broadcasts its own tag, and it can then be reallocated.
- R11: A broadcast whose tag matches no waiting slot changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code to store |
| iss_vj | input | DATA_W | First operand value (used when `iss_qj` is 0) |
| iss_qj | input | TAG_W | First operand producer tag (0 means value present) |
| iss_vk | input | DATA_W | Second operand value (used when `iss_qk` is 0) |
| iss_qk | input | TAG_W | Second operand producer tag (0 means value present) |
| iss_stall | output | 1 | All entries occupied; issue is refused |
| bus_valid | input | 1 | Result bus carries a broadcast this cycle |
| bus_tag | input | TAG_W | Tag of the broadcasting producer |
| bus_value | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | An entry is sent to the unit this cycle |
| disp_op | output | OP_W | Operation of the sent entry |
| disp_vj | output | DATA_W | First operand of the sent entry |
| disp_vk | output | DATA_W | Second operand of the sent entry |
| disp_tag | output | TAG_W | Tag of the sent entry |

## Verification
The bench delivers the two operands of one entry in separate broadcasts. A design that needs both operands at once, or that overwrites one slot when the other captures, would send wrong values or never send the entry.

The bench also broadcasts a producer tag in the very cycle its consumer issues. A design that snoops only entries already held would wait forever for that operand.

The bench fills the bank, offers an issue that is already ready while the bank is full, then releases all entries together. A design that lets the refused request slip in, picks entries by the wrong priority, or ignores the unit's busy window shows it in the order and spacing of the sent tags.

Freeing an entry and reissuing into it checks two things. The tag must be reused. The freed entry must win over older ready entries with higher indices.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Lifecycle of one reservation entry.
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_HELD = 2'd1,
    ST_SENT = 2'd2
  } ent_state_t;
endpackage

// File: rtl/rs_slot.sv
// One operand slot: a value and the tag of its pending producer.
module rs_slot #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_val,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_value,
  output logic [DATA_W-1:0] val,
  output logic [TAG_W-1:0]  tag
);
  function automatic logic hit(input logic [TAG_W-1:0] want, input logic bv,
                               input logic [TAG_W-1:0] bt);
    return bv && (want != '0) && (bt == want);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      tag <= '0;
    end else if (load) begin
      if (hit(in_tag, bus_valid, bus_tag)) begin
        val <= bus_value;
        tag <= '0;
      end else begin
        val <= in_val;
        tag <= in_tag;
      end
    end else if (hit(tag, bus_valid, bus_tag)) begin
      val <= bus_value;
      tag <= '0;
    end
  end
endmodule

// File: rtl/rs_entry.sv
// One reservation entry: state, operation and two capturing slots.
module rs_entry import rs_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 3,
  parameter logic [TAG_W-1:0] MY_TAG = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_vj,
  input  logic [TAG_W-1:0]  in_qj,
  input  logic [DATA_W-1:0] in_vk,
  input  logic [TAG_W-1:0]  in_qk,
  input  logic              send,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_value,
  output logic              busy,
  output logic              ready,
  output logic              sent,
  output logic              freed,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk
);
  ent_state_t       state;
  logic [TAG_W-1:0] qj, qk;

  rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot_j (
    .clk(clk), .rst_n(rst_n), .load(alloc), .in_val(in_vj), .in_tag(in_qj),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
    .val(vj), .tag(qj));

  rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot_k (
    .clk(clk), .rst_n(rst_n), .load(alloc), .in_val(in_vk), .in_tag(in_qk),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
    .val(vk), .tag(qk));

  assign busy  = (state != ST_FREE);
  assign sent  = (state == ST_SENT);
  assign ready = (state == ST_HELD) && (qj == '0) && (qk == '0);
  assign freed = sent && bus_valid && (bus_tag == MY_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FREE;
      op    <= '0;
    end else begin
      if (alloc) begin
        state <= ST_HELD;
        op    <= in_op;
      end else if (send) begin
        state <= ST_SENT;
      end else if (freed) begin
        state <= ST_FREE;
      end
    end
  end
endmodule

// File: rtl/rs_pick.sv
// Lowest-index one-hot grant.
module rs_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/rs_fu_timer.sv
// Functional-unit occupancy: busy for FU_LAT cycles from each start.
module rs_fu_timer #(
  parameter int FU_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic free
);
  localparam int CNT_W = (FU_LAT > 1) ? $clog2(FU_LAT + 1) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(FU_LAT - 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= RELOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign free = (cnt == '0);
endmodule

// File: rtl/rs_bank.sv
module rs_bank import rs_pkg::*; #(
  parameter int NUM_ENT = 4,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 3,
  parameter int UNIT_W  = 2,
  parameter logic [UNIT_W-1:0] UNIT_CODE = 1,
  parameter int FU_LAT  = 3,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int TAG_W  = UNIT_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  output logic              iss_stall,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_value,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_vj,
  output logic [DATA_W-1:0] disp_vk,
  output logic [TAG_W-1:0]  disp_tag
);
  function automatic logic [TAG_W-1:0] make_tag(input int idx);
    logic [IDX_W-1:0] ix;
    ix = IDX_W'(idx);
    return {UNIT_CODE, ix};
  endfunction

  // Named internal events, also observed by the bound checker.
  logic [NUM_ENT-1:0] ent_busy, ent_ready, ent_sent, ent_freed;
  logic [NUM_ENT-1:0] alloc_sel, disp_sel;
  logic               alloc_fire, any_free, any_ready, fu_free;

  logic [OP_W-1:0]   e_op [NUM_ENT];
  logic [DATA_W-1:0] e_vj [NUM_ENT];
  logic [DATA_W-1:0] e_vk [NUM_ENT];

  rs_pick #(.N(NUM_ENT)) u_alloc_pick (
    .req(~ent_busy), .grant(alloc_sel), .any(any_free));

  rs_pick #(.N(NUM_ENT)) u_disp_pick (
    .req(ent_ready), .grant(disp_sel), .any(any_ready));

  rs_fu_timer #(.FU_LAT(FU_LAT)) u_fu (
    .clk(clk), .rst_n(rst_n), .start(disp_valid), .free(fu_free));

  assign iss_stall  = !any_free;
  assign alloc_fire = iss_valid && any_free;
  assign disp_valid = any_ready && fu_free;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    rs_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .MY_TAG(make_tag(g))
    ) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_fire && alloc_sel[g]),
      .in_op(iss_op), .in_vj(iss_vj), .in_qj(iss_qj),
      .in_vk(iss_vk), .in_qk(iss_qk),
      .send(disp_valid && disp_sel[g]),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
      .busy(ent_busy[g]), .ready(ent_ready[g]), .sent(ent_sent[g]),
      .freed(ent_freed[g]),
      .op(e_op[g]), .vj(e_vj[g]), .vk(e_vk[g]));
  end

  always_comb begin
    disp_op  = '0;
    disp_vj  = '0;
    disp_vk  = '0;
    disp_tag = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (disp_sel[i]) begin
        disp_op  = disp_op  | e_op[i];
        disp_vj  = disp_vj  | e_vj[i];
        disp_vk  = disp_vk  | e_vk[i];
        disp_tag = disp_tag | make_tag(i);
      end
    end
  end
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
  parameter int NUM_ENT = 4,
  parameter int FU_LAT  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_stall,
  input logic               disp_valid,
  input logic [NUM_ENT-1:0] ent_busy,
  input logic [NUM_ENT-1:0] ent_ready,
  input logic [NUM_ENT-1:0] ent_sent,
  input logic [NUM_ENT-1:0] ent_freed,
  input logic [NUM_ENT-1:0] alloc_sel,
  input logic [NUM_ENT-1:0] disp_sel
);
  localparam int GW = $clog2(FU_LAT + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)                   gap <= GW'(FU_LAT);
    else if (disp_valid)          gap <= GW'(1);
    else if (gap < GW'(FU_LAT))   gap <= gap + 1'b1;
  end

  AST_ALLOC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_sel)); // R2
  AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    iss_stall |=> $countones(ent_busy) <= $past($countones(ent_busy))); // R3
  AST_DISP_READY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ((disp_sel & ~ent_ready) == '0)); // R7
  AST_DISP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_sel)); // R8
  AST_FU_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> gap >= GW'(FU_LAT)); // R9
  AST_SENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> ((ent_sent & $past(disp_sel)) == $past(disp_sel))); // R10
  AST_FREE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_freed != '0) |=> ((ent_busy & $past(ent_freed)) == '0)); // R10
endmodule

bind rs_bank rs_bank_chk #(.NUM_ENT(NUM_ENT), .FU_LAT(FU_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_stall(iss_stall), .disp_valid(disp_valid),
  .ent_busy(ent_busy), .ent_ready(ent_ready), .ent_sent(ent_sent),
  .ent_freed(ent_freed), .alloc_sel(alloc_sel), .disp_sel(disp_sel));

// File: tb/rs_bank_tb.sv
`timescale 1ns/1ps
module rs_bank_tb;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int OW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic [OW-1:0] iss_op = '0;
  logic [DW-1:0] iss_vj = '0, iss_vk = '0;
  logic [TW-1:0] iss_qj = '0, iss_qk = '0;
  logic          iss_stall;
  logic          bus_valid = 1'b0;
  logic [TW-1:0] bus_tag = '0;
  logic [DW-1:0] bus_value = '0;
  logic          disp_valid;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_vj, disp_vk;
  logic [TW-1:0] disp_tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rs_bank u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
    .iss_stall(iss_stall), .bus_valid(bus_valid), .bus_tag(bus_tag),
    .bus_value(bus_value), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_vj(disp_vj), .disp_vk(disp_vk), .disp_tag(disp_tag));

  // Tag of entry idx: unit code 1 in the upper two bits, index below.
  function automatic logic [TW-1:0] tag_of(input int idx);
    return TW'(4 + idx);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    iss_valid = 1'b0;
    bus_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; iss_valid = 1'b0; bus_valid = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic set_issue(input logic [OW-1:0] op, input logic [DW-1:0] vj,
                           input logic [TW-1:0] qj, input logic [DW-1:0] vk,
                           input logic [TW-1:0] qk);
    iss_valid = 1'b1; iss_op = op;
    iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
  endtask

  task automatic set_bus(input logic [TW-1:0] t, input logic [DW-1:0] v);
    bus_valid = 1'b1; bus_tag = t; bus_value = v;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "stall after reset", iss_stall, 0);
    chk("R1", "disp_valid after reset", disp_valid, 0);
  endtask

  task automatic t_ready_issue();
    do_reset();
    set_issue(3'd1, 16'h0010, 0, 16'h0020, 0);
    step();
    chk("R4", "ready entry sends", disp_valid, 1);
    chk("R2", "first entry tag", disp_tag, tag_of(0));
    chk("R2", "op", disp_op, 1);
    chk("R4", "vj", disp_vj, 16'h0010);
    chk("R4", "vk", disp_vk, 16'h0020);
    step();
    chk("R10", "not resent", disp_valid, 0);
  endtask

  task automatic t_split_capture();
    do_reset();
    set_issue(3'd2, 16'hdead, 4'd9, 16'hbeef, 4'd10);
    step();
    chk("R7", "waits on both", disp_valid, 0);
    set_bus(4'd11, 16'h0055);
    step();
    chk("R11", "unmatched tag ignored", disp_valid, 0);
    set_bus(4'd9, 16'h0077);
    step();
    chk("R7", "one operand only", disp_valid, 0);
    set_bus(4'd10, 16'h0088);
    step();
    chk("R5", "both captured", disp_valid, 1);
    chk("R5", "vj captured", disp_vj, 16'h0077);
    chk("R5", "vk captured", disp_vk, 16'h0088);
    chk("R11", "vk not from unmatched", disp_vk, 16'h0088);
  endtask

  task automatic t_same_cycle();
    do_reset();
    set_issue(3'd3, 16'h0000, 4'd9, 16'h0003, 0);
    set_bus(4'd9, 16'h0066);
    step();
    chk("R6", "issue-cycle capture sends", disp_valid, 1);
    chk("R6", "vj from bus", disp_vj, 16'h0066);
    chk("R6", "vk value", disp_vk, 16'h0003);
  endtask

  task automatic t_full_order();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      set_issue(OW'(i + 1), 16'h0000, 4'd12, DW'(i), 0);
      step();
    end
    chk("R3", "stall when full", iss_stall, 1);
    chk("R7", "none ready", disp_valid, 0);
    set_issue(3'd7, 16'h0001, 0, 16'h0002, 0);
    step();
    chk("R3", "refused issue not sent", disp_valid, 0);
    set_bus(4'd12, 16'h0100);
    step();
    chk("R8", "lowest sends first", disp_tag, tag_of(0));
    chk("R8", "op of entry 0", disp_op, 1);
    step();
    chk("R9", "busy cycle 1", disp_valid, 0);
    step();
    chk("R9", "busy cycle 2", disp_valid, 0);
    step();
    chk("R9", "send after latency", disp_valid, 1);
    chk("R10", "entry 0 not resent", disp_tag, tag_of(1));
    set_bus(tag_of(0), 16'h0999);
    step();
    chk("R10", "freed entry releases stall", iss_stall, 0);
    set_issue(3'd6, 16'h0001, 0, 16'h0002, 0);
    step();
    chk("R9", "still busy", disp_valid, 0);
    step();
    chk("R10", "reused entry sends", disp_valid, 1);
    chk("R10", "reused tag", disp_tag, tag_of(0));
    chk("R8", "reused lowest wins", disp_op, 6);
    chk("R3", "stalled issue never stored", (disp_op == 7), 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ready_issue();
    t_split_capture();
    t_same_cycle();
    t_full_order();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule